// File: doc/BRIEF.md
# Single-Instruction Move Processor Core

This block is a minimal processor core that has exactly one operation: it copies a word from one bus address to another. Instructions carry no opcode. Each instruction is a pair of consecutive words in memory: a source address followed by a destination address. The core reads both words and then reads the data word at the source address. It then writes that data to the destination address. If the destination address is zero, the data is loaded into the program counter instead, and that load is the jump.

The core has no arithmetic, no comparison logic and no halt state. Computation, conditional behaviour and stopping are left to devices on the shared bus, or to a jump that targets itself. The core drives one synchronous memory/peripheral bus with an address, write data, a read strobe and a write strobe. Read data comes back one cycle after the read strobe. A debug port shows the program counter, the state of the sequencer and a retire pulse, so that execution can be traced against a reference model.

Top module: `movcore`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the program counter equals START_ADDR, the state output is 0 (source fetch) and the write strobe is low.
- R2: Each instruction takes four single-cycle states in a fixed order, shown on dbg_state: 0 = fetch source address, 1 = fetch destination address, 2 = read data, 3 = execute. After 3 the sequence returns to 0.
- R3: In states 0, 1 and 2 the read strobe is high and the bus address is pc, pc+1 and the fetched source address, in that order. Read data is taken from the cycle that follows each read.
- R4: In state 3 with a nonzero destination address, the write strobe is high, the bus address is the destination address, and the write data is the word read from the source, unchanged.
- R5: In state 3 with a destination address of zero, the write strobe stays low and the program counter is loaded with the word read from the source. The next fetch starts at that address with no added increment.
- R6: After a move with a nonzero destination, the program counter advances by exactly 2.
- R7: The read strobe and the write strobe are never high in the same cycle. The read strobe is low in state 3.
- R8: dbg_retire is high for exactly one cycle per instruction, in state 3, and low in every other state.
- R9: There is no halt. A jump whose target is its own address makes the core fetch and execute that same instruction again and again, with the program counter held at that address.
- R10: One parameter W sets both the address width and the data width, with a default of 16. Elaboration rejects W below 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | W | Bus address |
| bus_wdata | output | W | Write data |
| bus_rdata | input | W | Read data, valid the cycle after a read |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| dbg_pc | output | W | Program counter |
| dbg_state | output | 2 | Sequencer state (0 to 3) |
| dbg_retire | output | 1 | One-cycle pulse when an instruction completes |

## Verification
The bench runs a behavioural reference model next to the core and compares the core against it on every clock. It drives a program with plain moves, a forward jump over words that must never run, self-modifying code that rewrites the destination of the next instruction, and a final jump to itself. If the core advanced the program counter after a jump, it would execute the skipped words and corrupt a guard location. If it wrote on a zero destination, memory at address 0 would change. If it fetched the operand words early or late, the rewritten destination would land in the wrong place. If it stopped after the self-jump, the loop would no longer show the expected fetch addresses and retire pulses.

// File: rtl/movcore_pkg.sv
package movcore_pkg;
   typedef enum logic [1:0] {
      ST_FSRC = 2'd0,
      ST_FDST = 2'd1,
      ST_RDAT = 2'd2,
      ST_EXEC = 2'd3
   } mc_state_e;
endpackage

// File: rtl/movcore_seq.sv
module movcore_seq
   import movcore_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   output mc_state_e state
);
   mc_state_e nxt;

   always_comb begin
      unique case (state)
         ST_FSRC: nxt = ST_FDST;
         ST_FDST: nxt = ST_RDAT;
         ST_RDAT: nxt = ST_EXEC;
         default: nxt = ST_FSRC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FSRC;
      else        state <= nxt;
   end

   // R2: fixed state order
   p_exec_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_EXEC |=> state == ST_FSRC);
   p_fsrc_then_fdst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FSRC |=> state == ST_FDST);
endmodule

// File: rtl/movcore_opreg.sv
module movcore_opreg
   import movcore_pkg::*;
#(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  mc_state_e    state,
   input  logic [W-1:0] rdata,
   output logic [W-1:0] src,
   output logic [W-1:0] dst
);
   // The word read in FSRC comes back during FDST; the word read in FDST during RDAT.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
      end else begin
         if (state == ST_FDST) src <= rdata;
         if (state == ST_RDAT) dst <= rdata;
      end
   end

   // R3: the source operand is stable while the data read uses it
   p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_EXEC |-> $stable(src));
endmodule

// File: rtl/movcore_pc.sv
module movcore_pc
   import movcore_pkg::*;
#(
   parameter int          W          = 16,
   parameter logic [W-1:0] START_ADDR = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  mc_state_e    state,
   input  logic         jump,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] pc
);
   localparam logic [W-1:0] STEP = W'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pc <= START_ADDR;
      else if (state == ST_EXEC)  pc <= jump ? ld_val : pc + STEP;
   end

   // R6: a plain move advances by two words
   p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && !jump) |=> pc == $past(pc) + STEP);
   // R5: a jump loads the read word with no increment
   p_pc_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && jump) |=> pc == $past(ld_val));
   // R2: pc holds steady outside the execute state
   p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_EXEC) |=> pc == $past(pc));
endmodule

// File: rtl/movcore.sv
module movcore
   import movcore_pkg::*;
#(
   parameter int          W          = 16,
   parameter logic [W-1:0] START_ADDR = W'(16)
)(
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] bus_addr,
   output logic [W-1:0] bus_wdata,
   input  logic [W-1:0] bus_rdata,
   output logic         bus_rd,
   output logic         bus_wr,
   output logic [W-1:0] dbg_pc,
   output logic [1:0]   dbg_state,
   output logic         dbg_retire
);
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 2) begin : g_bad_width
         $error("movcore: W must be at least 2");
      end
   endgenerate

   mc_state_e    state;
   logic [W-1:0] pc, src, dst;
   logic         jump;

   movcore_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state)
   );

   movcore_opreg #(.W(W)) u_ops (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .rdata (bus_rdata),
      .src   (src),
      .dst   (dst)
   );

   assign jump = (dst == '0);

   movcore_pc #(.W(W), .START_ADDR(START_ADDR)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .state  (state),
      .jump   (jump),
      .ld_val (bus_rdata),
      .pc     (pc)
   );

   always_comb begin
      bus_rd    = 1'b1;
      bus_wr    = 1'b0;
      bus_addr  = pc;
      bus_wdata = bus_rdata;
      unique case (state)
         ST_FSRC: bus_addr = pc;
         ST_FDST: bus_addr = pc + ONE;
         ST_RDAT: bus_addr = src;
         default: begin
            bus_rd   = 1'b0;
            bus_wr   = !jump;
            bus_addr = jump ? '0 : dst;
         end
      endcase
   end

   assign dbg_pc     = pc;
   assign dbg_state  = state;
   assign dbg_retire = (state == ST_EXEC);

   // R7: strobes are exclusive
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
   // R5: no write when the destination operand is zero
   p_jump_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_retire && dst == '0) |-> !bus_wr);
   // R8: retire never lasts two cycles
   p_retire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_retire |=> !dbg_retire);
   // R3: the destination fetch follows the source fetch at the next word
   p_fetch_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FSRC) |=> bus_addr == $past(bus_addr) + ONE);
endmodule

// File: tb/sim_movcore.sv
module sim_movcore;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam logic [W-1:0] START = 16'd16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] bus_addr, bus_wdata, bus_rdata, dbg_pc;
   logic bus_rd, bus_wr, dbg_retire;
   logic [1:0] dbg_state;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] mem  [0:255];
   logic [W-1:0] rmem [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   movcore #(.W(W), .START_ADDR(START)) u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr),
      .dbg_pc(dbg_pc), .dbg_state(dbg_state), .dbg_retire(dbg_retire)
   );

   // bus memory: one-cycle read latency
   always @(posedge clk) begin
      if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
      bus_rdata <= mem[bus_addr[7:0]];
   end

   task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic put(input int a, input logic [W-1:0] v);
      mem[a] = v;
      rmem[a] = v;
   endtask

   // reference model state
   logic [W-1:0] m_pc, m_src, m_dst, m_val;
   int phase = 0;
   int retires = 0;

   task automatic model_cycle();
      chk("R8", "retire", W'(dbg_retire), W'(phase == 3));
      chk("R1", "pc", dbg_pc, m_pc);
      chk("R2", "state", W'(dbg_state), W'(phase));
      chk("R7", "rd/wr exclusive", W'(bus_rd & bus_wr), '0);
      case (phase)
         0: begin
            chk("R3", "rd fsrc", W'(bus_rd), 1);
            chk("R3", "addr fsrc", bus_addr, m_pc);
            chk("R1", "wr fsrc", W'(bus_wr), 0);
         end
         1: begin
            chk("R3", "rd fdst", W'(bus_rd), 1);
            chk("R3", "addr fdst", bus_addr, m_pc + 1);
            m_src = rmem[m_pc[7:0]];
            m_dst = rmem[8'(m_pc + 1)];
         end
         2: begin
            chk("R3", "rd data", W'(bus_rd), 1);
            chk("R3", "addr data", bus_addr, m_src);
            m_val = rmem[m_src[7:0]];
         end
         default: begin
            chk("R7", "rd low in exec", W'(bus_rd), 0);
            retires++;
            if (m_dst != 0) begin
               chk("R4", "wr", W'(bus_wr), 1);
               chk("R4", "waddr", bus_addr, m_dst);
               chk("R4", "wdata", bus_wdata, m_val);
               rmem[m_dst[7:0]] = m_val;
               m_pc = m_pc + 2;
            end else begin
               chk("R5", "no write on jump", W'(bus_wr), 0);
               m_pc = m_val;
            end
         end
      endcase
      phase = (phase + 1) % 4;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) put(i, '0);
      put(100, 16'h1234); put(102, 16'hBEEF); put(104, 16'd30);
      put(107, 16'd108); put(110, 16'd36);
      put(16, 16'd100); put(17, 16'd101);   // move
      put(18, 16'd102); put(19, 16'd103);   // move
      put(20, 16'd104); put(21, 16'd0);     // jump to 30
      put(22, 16'd100); put(23, 16'd105);   // skipped
      put(30, 16'd101); put(31, 16'd106);   // move
      put(32, 16'd107); put(33, 16'd35);    // rewrite next dst
      put(34, 16'd101); put(35, 16'd109);   // dst becomes 108
      put(36, 16'd110); put(37, 16'd0);     // self jump
      m_pc = START;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "reset pc", dbg_pc, START);
      chk("R1", "reset state", W'(dbg_state), 0);
      chk("R1", "reset wr", W'(bus_wr), 0);
      chk("R10", "width", W'($bits(bus_addr)), 16);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int c = 0; c < 160; c++) begin
         model_cycle();
         @(negedge clk);
         #1;
      end
      chk("R4", "mem[101]", mem[101], 16'h1234);
      chk("R4", "mem[103]", mem[103], 16'hBEEF);
      chk("R5", "skipped mem[105]", mem[105], 16'h0000);
      chk("R5", "mem[0] untouched", mem[0], 16'h0000);
      chk("R6", "mem[106]", mem[106], 16'h1234);
      chk("R3", "self-modified dst mem[108]", mem[108], 16'h1234);
      chk("R3", "old dst mem[109]", mem[109], 16'h0000);
      chk("R9", "looping pc", dbg_pc, 16'd36);
      chk("R9", "retire count", W'(retires), 16'd40);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule